// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block divides one fast source clock into two output banks, each with its own divide ratio. Bank A drives one true/complement output pair, and its ratio comes from the set {1, 2, 3, 4}. Bank B drives two pairs that carry the same clock, and its ratio comes from the set {2, 4, 5, 8}. Every ratio gives a 50% duty cycle, including the odd ones. To do this the block uses both edges of the source clock: the first half of each output period lasts N source half-periods.

Each bank has an enable and a 2-bit ratio select, and both are captured on the falling edge of the source clock. A bank starts a new output period only on a rising edge that ends the previous period, or on any rising edge while the bank is idle. Because of this, a change of enable or select never cuts a pulse short and never stretches one. A single active-high master reset clears both banks asynchronously and forces every true output low.

Top module: `clkdiv_dualbank`

## Requirements
- R1: While `mrst` is high, every true output is 0 and every complement output is 1, and all divider state is cleared.
- R2: Bank A ratio codes are 00 = divide by 1, 01 = divide by 2, 10 = divide by 3 and 11 = divide by 4.
- R3: Bank B ratio codes are 00 = divide by 2, 01 = divide by 4, 10 = divide by 5 and 11 = divide by 8.
- R4: An active period of ratio N starts on a rising source edge. The output is high for the first N source half-periods and low for the next N, so odd ratios also keep a 50% duty cycle.
- R5: Each complement output is always the logical inverse of its true output.
- R6: Both Bank B pairs carry identical values at all times.
- R7: The enable is captured on each falling edge. A rising edge that closes a period, or that arrives while the bank is idle, starts a new period only if the last captured enable is 1; otherwise the bank idles with its true output low. A period that has started always completes.
- R8: The captured ratio select is applied only at the start of a period. A select change in the middle of a period leaves that period unchanged.
- R9: At divide by 1, the Bank A true output follows the source clock high for every active period.
- R10: After `mrst` falls, the first output high phase begins on the first rising edge that follows the first falling edge at which the enable is captured as 1.
- R11: The two banks run independently. The enable and select of one bank have no effect on the other bank's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| mrst | input | 1 | Asynchronous active-high master reset |
| a_sel | input | 2 | Bank A ratio select code |
| a_en | input | 1 | Bank A enable |
| b_sel | input | 2 | Bank B ratio select code |
| b_en | input | 1 | Bank B enable |
| a_q | output | A_PAIRS (1) | Bank A true outputs |
| a_qn | output | A_PAIRS (1) | Bank A complement outputs |
| b_q | output | B_PAIRS (2) | Bank B true outputs |
| b_qn | output | B_PAIRS (2) | Bank B complement outputs |

## Verification
If a period counter holds a wrong value, the fault shows at the ports as a high or low phase of the wrong length, inside the period where the fault occurs. If the ratio register is wrong, every following period has the wrong length. If the enable handling is wrong, the bank starts or stops one period early or late, or it produces a short pulse. Because the output is compared in every source half-period, all of these faults appear within at most one output period, which is at most sixteen half-periods.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   typedef logic [1:0] divsel_t;

   // Ratio chosen by a 2-bit select code from a four-entry set
   function automatic int unsigned pick_ratio(input divsel_t code,
                                              input int unsigned r0,
                                              input int unsigned r1,
                                              input int unsigned r2,
                                              input int unsigned r3);
      case (code)
         2'd0:    return r0;
         2'd1:    return r1;
         2'd2:    return r2;
         default: return r3;
      endcase
   endfunction

   function automatic int unsigned max_of4(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned c,
                                           input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/clkdiv_fsync.sv
// Captures control inputs on the falling source edge
module clkdiv_fsync #(
   parameter int unsigned   W       = 1,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         mrst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_width
         $error("clkdiv_fsync: W must be at least 1");
      end
   endgenerate

   always_ff @(negedge clk or posedge mrst) begin
      if (mrst) q <= RST_VAL;
      else      q <= d;
   end
endmodule

// File: rtl/clkdiv_pairs.sv
// Fans one divided clock out to NPAIR true/complement pairs
module clkdiv_pairs #(
   parameter int unsigned NPAIR = 1
) (
   input  logic             core,
   output logic [NPAIR-1:0] q_true,
   output logic [NPAIR-1:0] q_comp
);
   generate
      if (NPAIR < 1) begin : g_bad_pairs
         $error("clkdiv_pairs: NPAIR must be at least 1");
      end
      for (genvar i = 0; i < NPAIR; i++) begin : g_pair
         assign q_true[i] = core;
         assign q_comp[i] = ~core;
      end
   endgenerate
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
   import clkdiv_pkg::*;
#(
   parameter int unsigned R0    = 2,
   parameter int unsigned R1    = 4,
   parameter int unsigned R2    = 5,
   parameter int unsigned R3    = 8,
   parameter int unsigned NPAIR = 1
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             en_in,
   input  divsel_t          sel_in,
   output logic [NPAIR-1:0] q_true,
   output logic [NPAIR-1:0] q_comp,
   output logic             bnd_o,
   output logic             es_o,
   output logic             run_o,
   output logic [7:0]       ratio_o
);
   localparam int unsigned RMAX    = max_of4(R0, R1, R2, R3);
   localparam int unsigned RW      = $clog2(RMAX + 1);
   localparam bit          HAS_BYP = (R0 == 1) || (R1 == 1) || (R2 == 1) || (R3 == 1);

   generate
      if (R0 < 1 || R1 < 1 || R2 < 1 || R3 < 1) begin : g_bad_ratio
         $error("clkdiv_bank: every ratio must be at least 1");
      end
      if (RMAX > 255) begin : g_bad_max
         $error("clkdiv_bank: ratios above 255 are not supported");
      end
   endgenerate

   // falling-edge captured controls
   logic    es;
   divsel_t ss;
   clkdiv_fsync #(.W(3), .RST_VAL(3'b011)) u_sync (
      .clk  (clk),
      .mrst (mrst),
      .d    ({en_in, sel_in}),
      .q    ({es, ss})
   );

   logic          run_q;
   logic [RW-1:0] ratio_q;
   logic [RW-1:0] cnt_q;
   logic          p_q;
   logic          n_q;
   logic          g_q;
   logic          bnd;
   logic [RW-1:0] sel_ratio;
   logic [RW-1:0] sel_half;
   logic [RW-1:0] cur_half;
   logic [RW-1:0] cnt_nx;

   assign sel_ratio = RW'(pick_ratio(ss, R0, R1, R2, R3));
   assign sel_half  = sel_ratio >> 1;
   assign cur_half  = ratio_q >> 1;
   assign cnt_nx    = cnt_q + RW'(1);
   assign bnd       = !run_q || (cnt_q == ratio_q - RW'(1));

   // period sequencing on the rising edge
   always_ff @(posedge clk or posedge mrst) begin
      if (mrst) begin
         run_q   <= 1'b0;
         cnt_q   <= '0;
         ratio_q <= RW'(R3);
         p_q     <= 1'b0;
      end else if (bnd) begin
         run_q   <= es;
         cnt_q   <= '0;
         ratio_q <= sel_ratio;
         p_q     <= es && (sel_half != '0);
      end else begin
         cnt_q   <= cnt_nx;
         p_q     <= cnt_nx < cur_half;
      end
   end

   // half-cycle extension for odd ratios
   always_ff @(negedge clk or posedge mrst) begin
      if (mrst) n_q <= 1'b0;
      else      n_q <= p_q & ratio_q[0];
   end

   // bypass gate for a ratio of one, decided while the clock is low
   generate
      if (HAS_BYP) begin : g_byp
         always_ff @(negedge clk or posedge mrst) begin
            if (mrst) g_q <= 1'b0;
            else      g_q <= bnd && en_in && (pick_ratio(sel_in, R0, R1, R2, R3) == 1);
         end
      end else begin : g_nobyp
         assign g_q = 1'b0;
      end
   endgenerate

   logic core;
   assign core = (clk & g_q) | p_q | n_q;

   clkdiv_pairs #(.NPAIR(NPAIR)) u_pairs (
      .core   (core),
      .q_true (q_true),
      .q_comp (q_comp)
   );

   assign bnd_o   = bnd;
   assign es_o    = es;
   assign run_o   = run_q;
   assign ratio_o = 8'(ratio_q);
endmodule

// File: rtl/clkdiv_dualbank.sv
module clkdiv_dualbank #(
   parameter int unsigned A_PAIRS = 1,
   parameter int unsigned B_PAIRS = 2,
   parameter int unsigned A_R0    = 1,
   parameter int unsigned A_R1    = 2,
   parameter int unsigned A_R2    = 3,
   parameter int unsigned A_R3    = 4,
   parameter int unsigned B_R0    = 2,
   parameter int unsigned B_R1    = 4,
   parameter int unsigned B_R2    = 5,
   parameter int unsigned B_R3    = 8
) (
   input  logic               clk_src,
   input  logic               mrst,
   input  logic [1:0]         a_sel,
   input  logic               a_en,
   input  logic [1:0]         b_sel,
   input  logic               b_en,
   output logic [A_PAIRS-1:0] a_q,
   output logic [A_PAIRS-1:0] a_qn,
   output logic [B_PAIRS-1:0] b_q,
   output logic [B_PAIRS-1:0] b_qn
);
   logic       a_bnd, a_es, a_run;
   logic [7:0] a_ratio;
   logic       b_bnd, b_es, b_run;
   logic [7:0] b_ratio;

   clkdiv_bank #(.R0(A_R0), .R1(A_R1), .R2(A_R2), .R3(A_R3), .NPAIR(A_PAIRS)) u_bank_a (
      .clk     (clk_src),
      .mrst    (mrst),
      .en_in   (a_en),
      .sel_in  (a_sel),
      .q_true  (a_q),
      .q_comp  (a_qn),
      .bnd_o   (a_bnd),
      .es_o    (a_es),
      .run_o   (a_run),
      .ratio_o (a_ratio)
   );

   clkdiv_bank #(.R0(B_R0), .R1(B_R1), .R2(B_R2), .R3(B_R3), .NPAIR(B_PAIRS)) u_bank_b (
      .clk     (clk_src),
      .mrst    (mrst),
      .en_in   (b_en),
      .sel_in  (b_sel),
      .q_true  (b_q),
      .q_comp  (b_qn),
      .bnd_o   (b_bnd),
      .es_o    (b_es),
      .run_o   (b_run),
      .ratio_o (b_ratio)
   );
endmodule

// File: rtl/clkdiv_dualbank_chk.sv
module clkdiv_dualbank_chk #(
   parameter int unsigned A_PAIRS = 1,
   parameter int unsigned B_PAIRS = 2
) (
   input logic               clk_src,
   input logic               mrst,
   input logic [A_PAIRS-1:0] a_q,
   input logic [A_PAIRS-1:0] a_qn,
   input logic [B_PAIRS-1:0] b_q,
   input logic [B_PAIRS-1:0] b_qn,
   input logic               a_bnd,
   input logic               a_es,
   input logic               a_run,
   input logic [7:0]         a_ratio,
   input logic               b_bnd,
   input logic               b_es,
   input logic               b_run,
   input logic [7:0]         b_ratio
);
   // R1
   always @(negedge clk_src) begin
      if (mrst) begin
         rst_outs_low_chk: assert (a_q == '0 && b_q == '0 && a_qn == '1 && b_qn == '1)
            else $error("outputs not in reset state");
      end
   end

   // R5
   pair_inverse_chk: assert property (@(negedge clk_src) disable iff (mrst)
      (a_qn == ~a_q) && (b_qn == ~b_q));

   // R6
   b_pairs_equal_chk: assert property (@(posedge clk_src) disable iff (mrst)
      (b_q == '0) || (b_q == '1));

   // R8
   a_ratio_hold_chk: assert property (@(posedge clk_src) disable iff (mrst)
      !a_bnd |=> $stable(a_ratio));

   // R8
   b_ratio_hold_chk: assert property (@(posedge clk_src) disable iff (mrst)
      !b_bnd |=> $stable(b_ratio));

   // R7
   b_idle_on_disable_chk: assert property (@(posedge clk_src) disable iff (mrst)
      (b_bnd && !b_es) |=> !b_run);

   // R7
   a_idle_on_disable_chk: assert property (@(posedge clk_src) disable iff (mrst)
      (a_bnd && !a_es) |=> !a_run);

   // R7
   idle_low_chk: assert property (@(posedge clk_src) disable iff (mrst)
      (!a_run |-> a_q == '0) and (!b_run |-> b_q == '0));
endmodule

bind clkdiv_dualbank clkdiv_dualbank_chk #(.A_PAIRS(A_PAIRS), .B_PAIRS(B_PAIRS)) u_chk (
   .clk_src (clk_src),
   .mrst    (mrst),
   .a_q     (a_q),
   .a_qn    (a_qn),
   .b_q     (b_q),
   .b_qn    (b_qn),
   .a_bnd   (a_bnd),
   .a_es    (a_es),
   .a_run   (a_run),
   .a_ratio (a_ratio),
   .b_bnd   (b_bnd),
   .b_es    (b_es),
   .b_run   (b_run),
   .b_ratio (b_ratio)
);

// File: tb/clkdiv_dualbank_bench.sv
module clkdiv_dualbank_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       mrst;
   logic [1:0] a_sel, b_sel;
   logic       a_en, b_en;
   logic [0:0] a_q, a_qn;
   logic [1:0] b_q, b_qn;

   clkdiv_dualbank u_clkdiv_dualbank (
      .clk_src (clk),
      .mrst    (mrst),
      .a_sel   (a_sel),
      .a_en    (a_en),
      .b_sel   (b_sel),
      .b_en    (b_en),
      .a_q     (a_q),
      .a_qn    (a_qn),
      .b_q     (b_q),
      .b_qn    (b_qn)
   );

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   bit    started = 0;
   string lab_a = "R1";
   string lab_b = "R1";

   // behavioural reference: per bank, half-period index within the period
   int m_ratio [2] = '{4, 8};
   int m_h     [2] = '{0, 0};
   bit m_act   [2] = '{0, 0};
   bit m_es    [2] = '{0, 0};
   int m_ss    [2] = '{3, 3};

   function automatic int ratio_of(int bank, int code);
      int ra [4] = '{1, 2, 3, 4};   // R2
      int rb [4] = '{2, 4, 5, 8};   // R3
      return (bank == 0) ? ra[code] : rb[code];
   endfunction

   function automatic bit exp_of(int bank);
      return !mrst && m_act[bank] && (m_h[bank] < m_ratio[bank]);
   endfunction

   always @(negedge clk) begin
      for (int b = 0; b < 2; b++) begin
         if (mrst) begin
            m_es[b] = 0;
            m_ss[b] = 3;
         end else begin
            m_es[b] = (b == 0) ? a_en : b_en;
            m_ss[b] = (b == 0) ? int'(a_sel) : int'(b_sel);
            m_h[b]++;
         end
      end
   end

   always @(posedge clk) begin
      for (int b = 0; b < 2; b++) begin
         if (mrst) begin
            m_act[b] = 0;
            m_h[b]   = 0;
         end else begin
            m_h[b]++;
            if (!m_act[b] || m_h[b] >= 2 * m_ratio[b]) begin
               m_act[b]   = m_es[b];
               m_ratio[b] = ratio_of(b, m_ss[b]);
               m_h[b]     = 0;
            end
         end
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
      end
   endtask

   // compare every half period, away from the edges
   always @(clk) begin
      #2;
      if (started && !done) begin
         bit ea, eb;
         ea = exp_of(0);
         eb = exp_of(1);
         chk(mrst ? "R1" : lab_a, "a_q",     a_q[0],  ea);
         chk(mrst ? "R1" : lab_b, "b_q[0]",  b_q[0],  eb);
         chk("R6",                "b_q[1]",  b_q[1],  eb);
         chk("R5",                "a_qn",    a_qn[0], ~ea);
         chk("R5",                "b_qn[0]", b_qn[0], ~eb);
         chk("R5",                "b_qn[1]", b_qn[1], ~eb);
      end
   end

   task automatic cycles(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      mrst = 1; a_en = 0; b_en = 0; a_sel = 2'd3; b_sel = 2'd3;
      started = 1;
      cycles(4);                         // R1 reset state
      a_en = 1; b_en = 1;
      cycles(2);
      lab_a = "R10"; lab_b = "R10";
      mrst = 0;                          // R10 start after release
      cycles(40);
      lab_a = "R2"; lab_b = "R4";
      b_sel = 2'd2;                      // odd ratio on B during R2 sweep
      for (int c = 0; c < 4; c++) begin
         a_sel = 2'(c);
         cycles(30);
      end
      lab_a = "R4"; lab_b = "R3";
      a_sel = 2'd2;                      // odd ratio on A during R3 sweep
      for (int c = 0; c < 4; c++) begin
         b_sel = 2'(c);
         cycles(40);
      end
      lab_a = "R8"; lab_b = "R8";        // mid-period select changes
      for (int k = 0; k < 20; k++) begin
         b_sel = (k % 2 == 0) ? 2'd3 : 2'd2;
         a_sel = (k % 3 == 0) ? 2'd3 : 2'd0;
         cycles(3);
      end
      lab_a = "R9"; a_sel = 2'd0;
      lab_b = "R4"; b_sel = 2'd2;
      cycles(20);
      lab_a = "R7"; lab_b = "R7";        // enable toggling mid-period
      b_sel = 2'd3;
      for (int k = 0; k < 16; k++) begin
         a_en = ~a_en;
         if (k % 2 == 0) b_en = ~b_en;
         cycles(5 + (k % 3));
      end
      a_sel = 2'd2;
      for (int k = 0; k < 10; k++) begin
         a_en = ~a_en;
         cycles(2 + (k % 4));
      end
      lab_a = "R11"; lab_b = "R11";      // one bank off, other running
      a_en = 0; b_en = 1; b_sel = 2'd1;
      cycles(30);
      a_en = 1; b_en = 0; a_sel = 2'd1; b_sel = 2'd0;
      cycles(30);
      b_en = 1;
      cycles(7);
      mrst = 1;                          // R1 reset mid-run
      cycles(4);
      lab_a = "R10"; lab_b = "R10";
      mrst = 0;
      cycles(30);
      finish_run();
   end
endmodule